// File: doc/BRIEF.md
# CCD Electronic Shutter Controller

This block decides, line by line, whether the CCD substrate discharge pulse fires. Within each field it asks for a discharge on the first lines. The lines that are left after the last discharge set the exposure. Three settings feed one speed level, from 0 to 8:

- a fixed speed chosen by three pins;
- a level that an iris loop raises or lowers by one step per field, following up/down decisions from an external comparator, with or without a floor at the base speed;
- a stop state that suppresses the discharge completely.

Level 0 means no discharge, so the whole field is exposed. Level 1 is the base speed: 1/100 s on a 60 Hz line standard and 1/120 s on a 50 Hz standard. Levels 2 to 8 are 1/250, 1/500, 1/1000, 1/2000, 1/5000, 1/10000 and 1/100000 s.

Line and field timing arrive as single-cycle strobes. A field strobe always comes together with the line strobe of the first line of the field. The mode pins, speed pins, standard select and comparator decisions are sampled only on a field strobe. A field is therefore never exposed with two different settings.

Top module: `ccd_shutter_ctrl`

## Requirements
- R1: The mode pins decode as {mode_sel_hi, mode_sel_lo}:
  - 00 is iris without floor;
  - 01 is iris with floor;
  - 10 is fixed speed;
  - 11 is stop.

  In fixed mode the comparator inputs have no effect on speed_idx.
- R2: In fixed mode the level is 8 minus the binary value {spd_pin2, spd_pin1, spd_pin0}. For example, all pins high (7) gives level 1 (base speed), and all pins low gives level 8 (1/100000 s). speed_idx shows the level.
- R3: The exposure in lines, E, is round(line_rate / speed_denominator), with a minimum of 1. For level L ≥ 1, sub_en pulses for one cycle, on the cycle after the line strobe, for each line number n < field_lines − E. Line number n counts from 0 at the field strobe.
- R4: std_ccir low selects 262 lines per field, a line rate of 15734 and a base denominator of 100. std_ccir high selects 312 lines, 15625 and 120.
- R5: In iris modes, at a field strobe the level changes as follows:
  - iris_up alone raises it by one;
  - iris_down alone lowers it by one;
  - both, or neither, leave it unchanged.
- R6: The iris level saturates at 8 at the top and at its floor at the bottom.
- R7: In iris mode with floor, the level never goes below 1. Entering that mode from level 0 sets the level to 1.
- R8: In iris mode without floor the level can reach 0. At level 0 no sub_en pulse occurs in the field.
- R9: In stop mode sub_en stays low for the whole field and the level holds.
- R10: Changes to the pins or to std_ccir in the middle of a field change neither that field's pulse count nor speed_idx until the next field strobe.
- R11: After reset, speed_idx is 0 and sub_en stays low until the first field strobe, even while line strobes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel_lo | input | 1 | Mode select, low bit |
| mode_sel_hi | input | 1 | Mode select, high bit |
| spd_pin0 | input | 1 | Fixed speed select, bit 0 |
| spd_pin1 | input | 1 | Fixed speed select, bit 1 |
| spd_pin2 | input | 1 | Fixed speed select, bit 2 |
| std_ccir | input | 1 | Line standard: 0 = 60 Hz, 1 = 50 Hz |
| line_strobe | input | 1 | One-cycle pulse at the start of each line |
| field_strobe | input | 1 | One-cycle pulse at the start of each field, coincident with a line strobe |
| iris_up | input | 1 | Comparator decision: faster shutter |
| iris_down | input | 1 | Comparator decision: slower shutter |
| sub_en | output | 1 | One-cycle discharge request for the current line |
| speed_idx | output | 4 | Current speed level, 0 to 8 |

## Verification
The hardest states to reach from the ports are the two ends of the iris range, and the step into the floored iris mode while the level is 0. Both need many whole fields of steady comparator decisions. The bench first sweeps every fixed code on both standards, which leaves the level at the base speed. It then steps down into level 0, climbs past level 8, and walks down against the floor. Finally it drops to level 0 once more and switches to the floored mode with no comparator input. A reference model runs alongside every clock and follows the pins, the standard and the line counting. Separately, each field's pulse total is compared with the line-count formula, so a wrong timing table shows up as a wrong count.

// File: rtl/shsub_pkg.sv
package shsub_pkg;

  typedef enum logic [1:0] {
    MODE_IRIS     = 2'b00,
    MODE_IRIS_LIM = 2'b01,
    MODE_FIXED    = 2'b10,
    MODE_STOP     = 2'b11
  } shsub_mode_e;

  localparam int unsigned SPEED_CODES = 8;
  localparam int unsigned LEVEL_MAX   = SPEED_CODES;
  localparam int unsigned LEVEL_W     = $clog2(LEVEL_MAX + 1);
  localparam int unsigned LEVEL_SLOTS = 1 << LEVEL_W;

  localparam logic [LEVEL_W-1:0] LVL_TOP = LEVEL_W'(LEVEL_MAX);
  localparam logic [LEVEL_W-1:0] LVL_ONE = LEVEL_W'(1);

  // Reciprocal of the exposure time in seconds for a speed code.
  function automatic int unsigned speed_denom(input logic ccir, input int unsigned code);
    case (code)
      0:       return ccir ? 120 : 100;
      1:       return 250;
      2:       return 500;
      3:       return 1000;
      4:       return 2000;
      5:       return 5000;
      6:       return 10000;
      default: return 100000;
    endcase
  endfunction

  // Exposure expressed in whole lines: rounded, never below one line.
  function automatic int unsigned exposure_lines(input logic ccir, input int unsigned code,
                                                 input int unsigned rate);
    int unsigned d;
    int unsigned e;
    d = speed_denom(ccir, code);
    e = (rate + d / 2) / d;
    return (e == 0) ? 1 : e;
  endfunction

  // Number of leading lines per field that carry a discharge pulse.
  function automatic int unsigned sub_line_limit(input logic ccir, input int unsigned level,
                                                 input int unsigned rate,
                                                 input int unsigned field_lines);
    int unsigned e;
    if (level == 0) return 0;
    e = exposure_lines(ccir, level - 1, rate);
    return (e >= field_lines) ? 0 : field_lines - e;
  endfunction

  function automatic logic is_iris(input shsub_mode_e m);
    return (m == MODE_IRIS) || (m == MODE_IRIS_LIM);
  endfunction

  // Fixed code: pins high mean slow; the level is the inverted code plus one.
  function automatic logic [LEVEL_W-1:0] level_from_pins(input logic p2, input logic p1,
                                                         input logic p0);
    logic [2:0] code;
    code = ~{p2, p1, p0};
    return LEVEL_W'(code) + LVL_ONE;
  endfunction

  function automatic logic [LEVEL_W-1:0] iris_step(input logic [LEVEL_W-1:0] lvl,
                                                   input logic up, input logic dn,
                                                   input logic floored);
    logic [LEVEL_W-1:0] floor_l;
    logic [LEVEL_W-1:0] r;
    floor_l = floored ? LVL_ONE : '0;
    r = lvl;
    if (up && !dn && (lvl < LVL_TOP)) r = lvl + LVL_ONE;
    else if (dn && !up && (lvl > floor_l)) r = lvl - LVL_ONE;
    if (r < floor_l) r = floor_l;
    return r;
  endfunction

endpackage

// File: rtl/shsub_field_regs.sv
module shsub_field_regs
  import shsub_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        field_strobe,
  input  logic        mode_sel_lo,
  input  logic        mode_sel_hi,
  input  logic        std_ccir,
  output shsub_mode_e mode_q,
  output shsub_mode_e mode_next,
  output logic        ccir_q,
  output logic        ccir_next
);

  assign mode_next = shsub_mode_e'({mode_sel_hi, mode_sel_lo});
  assign ccir_next = std_ccir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_STOP;
      ccir_q <= 1'b0;
    end else if (field_strobe) begin
      mode_q <= mode_next;
      ccir_q <= ccir_next;
    end
  end

  // R1: both select pins high at a field boundary yields the stop state
  a_r1_stop_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (field_strobe && mode_sel_hi && mode_sel_lo) |=> (mode_q == MODE_STOP));

  // R10: pin and standard changes between boundaries are not taken
  a_r10_std_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_strobe && (std_ccir != ccir_q)) |=> $stable(ccir_q));

endmodule

// File: rtl/shsub_level_ctrl.sv
module shsub_level_ctrl
  import shsub_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               field_strobe,
  input  shsub_mode_e        mode_next,
  input  shsub_mode_e        mode_q,
  input  logic               spd_pin0,
  input  logic               spd_pin1,
  input  logic               spd_pin2,
  input  logic               iris_up,
  input  logic               iris_down,
  output logic [LEVEL_W-1:0] lvl_q,
  output logic [LEVEL_W-1:0] lvl_next
);

  logic iris_evt;
  assign iris_evt = field_strobe && is_iris(mode_next);

  always_comb begin
    unique case (mode_next)
      MODE_FIXED:    lvl_next = level_from_pins(spd_pin2, spd_pin1, spd_pin0);
      MODE_IRIS:     lvl_next = iris_step(lvl_q, iris_up, iris_down, 1'b0);
      MODE_IRIS_LIM: lvl_next = iris_step(lvl_q, iris_up, iris_down, 1'b1);
      default:       lvl_next = lvl_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else if (field_strobe) lvl_q <= lvl_next;
  end

  // R10: level only moves on a field boundary
  a_r10_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !field_strobe |=> $stable(lvl_q));

  // R6: level stays inside the table
  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_TOP);

  // R7: floored iris never sits at level 0
  a_r7_limiter_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IRIS_LIM) |-> (lvl_q != '0));

  // R5: an iris boundary moves the level by at most one step
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    iris_evt |=> (({1'b0, lvl_q}) <= ({1'b0, $past(lvl_q)} + 1'b1)) &&
                 (({1'b0, lvl_q} + 1'b1) >= {1'b0, $past(lvl_q)}));

  // R9: stop state keeps the level
  a_r9_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (field_strobe && (mode_next == MODE_STOP)) |=> $stable(lvl_q));

endmodule

// File: rtl/shsub_line_gate.sv
module shsub_line_gate
  import shsub_pkg::*;
#(
  parameter int unsigned FIELD_LINES_EIA  = 262,
  parameter int unsigned FIELD_LINES_CCIR = 312,
  parameter int unsigned LINE_RATE_EIA    = 15734,
  parameter int unsigned LINE_RATE_CCIR   = 15625,
  parameter int unsigned LINE_W           = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_strobe,
  input  logic               field_strobe,
  input  shsub_mode_e        mode_q,
  input  shsub_mode_e        mode_next,
  input  logic               ccir_q,
  input  logic               ccir_next,
  input  logic [LEVEL_W-1:0] lvl_q,
  input  logic [LEVEL_W-1:0] lvl_next,
  output logic               sub_en
);

  localparam logic [LINE_W-1:0] LINE_SAT = {LINE_W{1'b1}};

  logic [LINE_W-1:0] lim_eia  [LEVEL_SLOTS];
  logic [LINE_W-1:0] lim_ccir [LEVEL_SLOTS];

  for (genvar g = 0; g < LEVEL_SLOTS; g++) begin : g_lim
    if (g <= LEVEL_MAX) begin : g_real
      assign lim_eia[g]  = LINE_W'(sub_line_limit(1'b0, g, LINE_RATE_EIA, FIELD_LINES_EIA));
      assign lim_ccir[g] = LINE_W'(sub_line_limit(1'b1, g, LINE_RATE_CCIR, FIELD_LINES_CCIR));
    end else begin : g_pad
      assign lim_eia[g]  = '0;
      assign lim_ccir[g] = '0;
    end
  end

  logic [LINE_W-1:0]  ln_q;
  logic [LINE_W-1:0]  ln_cur;
  logic [LINE_W-1:0]  limit;
  shsub_mode_e        use_mode;
  logic               use_ccir;
  logic [LEVEL_W-1:0] use_lvl;
  logic               pulse_ok;

  always_comb begin
    use_mode = field_strobe ? mode_next : mode_q;
    use_ccir = field_strobe ? ccir_next : ccir_q;
    use_lvl  = field_strobe ? lvl_next  : lvl_q;
    ln_cur   = field_strobe ? '0 : ln_q;
    limit    = use_ccir ? lim_ccir[use_lvl] : lim_eia[use_lvl];
    pulse_ok = line_strobe && (use_mode != MODE_STOP) && (ln_cur < limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ln_q   <= '0;
      sub_en <= 1'b0;
    end else begin
      sub_en <= pulse_ok;
      if (field_strobe) ln_q <= line_strobe ? LINE_W'(1) : '0;
      else if (line_strobe && (ln_q != LINE_SAT)) ln_q <= ln_q + 1'b1;
    end
  end

  // R3: a pulse is always the answer to a line strobe
  a_r3_after_line: assert property (@(posedge clk) disable iff (!rst_n)
    sub_en |-> $past(line_strobe));

  // R9: no pulse while stopped
  a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_strobe && (mode_q == MODE_STOP)) |=> !sub_en);

  // R8: level 0 means the whole field is exposed
  a_r8_open_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_strobe && (lvl_q == '0)) |=> !sub_en);

endmodule

// File: rtl/ccd_shutter_ctrl.sv
module ccd_shutter_ctrl
  import shsub_pkg::*;
#(
  parameter int unsigned FIELD_LINES_EIA  = 262,
  parameter int unsigned FIELD_LINES_CCIR = 312,
  parameter int unsigned LINE_RATE_EIA    = 15734,
  parameter int unsigned LINE_RATE_CCIR   = 15625,
  parameter int unsigned LINE_W           = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_sel_lo,
  input  logic               mode_sel_hi,
  input  logic               spd_pin0,
  input  logic               spd_pin1,
  input  logic               spd_pin2,
  input  logic               std_ccir,
  input  logic               line_strobe,
  input  logic               field_strobe,
  input  logic               iris_up,
  input  logic               iris_down,
  output logic               sub_en,
  output logic [LEVEL_W-1:0] speed_idx
);

  shsub_mode_e        mode_q;
  shsub_mode_e        mode_next;
  logic               ccir_q;
  logic               ccir_next;
  logic [LEVEL_W-1:0] lvl_q;
  logic [LEVEL_W-1:0] lvl_next;

  shsub_field_regs u_field (
    .clk          (clk),
    .rst_n        (rst_n),
    .field_strobe (field_strobe),
    .mode_sel_lo  (mode_sel_lo),
    .mode_sel_hi  (mode_sel_hi),
    .std_ccir     (std_ccir),
    .mode_q       (mode_q),
    .mode_next    (mode_next),
    .ccir_q       (ccir_q),
    .ccir_next    (ccir_next)
  );

  shsub_level_ctrl u_level (
    .clk          (clk),
    .rst_n        (rst_n),
    .field_strobe (field_strobe),
    .mode_next    (mode_next),
    .mode_q       (mode_q),
    .spd_pin0     (spd_pin0),
    .spd_pin1     (spd_pin1),
    .spd_pin2     (spd_pin2),
    .iris_up      (iris_up),
    .iris_down    (iris_down),
    .lvl_q        (lvl_q),
    .lvl_next     (lvl_next)
  );

  shsub_line_gate #(
    .FIELD_LINES_EIA  (FIELD_LINES_EIA),
    .FIELD_LINES_CCIR (FIELD_LINES_CCIR),
    .LINE_RATE_EIA    (LINE_RATE_EIA),
    .LINE_RATE_CCIR   (LINE_RATE_CCIR),
    .LINE_W           (LINE_W)
  ) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_strobe  (line_strobe),
    .field_strobe (field_strobe),
    .mode_q       (mode_q),
    .mode_next    (mode_next),
    .ccir_q       (ccir_q),
    .ccir_next    (ccir_next),
    .lvl_q        (lvl_q),
    .lvl_next     (lvl_next),
    .sub_en       (sub_en)
  );

  assign speed_idx = lvl_q;

  // R11: nothing is emitted before the first field boundary sets a mode
  a_r11_quiet_until_field: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_strobe && (mode_q == MODE_STOP) && (speed_idx == '0)) |=> !sub_en);

endmodule

// File: tb/tb_ccd_shutter_ctrl.sv
`timescale 1ns/1ps
module tb_ccd_shutter_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel_lo = 1'b1, mode_sel_hi = 1'b1;
  logic spd_pin0 = 1'b1, spd_pin1 = 1'b1, spd_pin2 = 1'b1;
  logic std_ccir = 1'b0;
  logic line_strobe = 1'b0, field_strobe = 1'b0;
  logic iris_up = 1'b0, iris_down = 1'b0;
  logic sub_en;
  logic [3:0] speed_idx;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  ccd_shutter_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_sel_lo(mode_sel_lo), .mode_sel_hi(mode_sel_hi),
    .spd_pin0(spd_pin0), .spd_pin1(spd_pin1), .spd_pin2(spd_pin2), .std_ccir(std_ccir),
    .line_strobe(line_strobe), .field_strobe(field_strobe),
    .iris_up(iris_up), .iris_down(iris_down), .sub_en(sub_en), .speed_idx(speed_idx)
  );

  always #2.5 clk = ~clk;

  // Reference: discharged lines per field from exposure time in seconds
  function automatic int ref_limit(input int lvl, input int ccir);
    real rate;
    real den;
    int  exp_l;
    int  lines;
    if (lvl == 0) return 0;
    rate  = ccir ? 15625.0 : 15734.0;
    lines = ccir ? 312 : 262;
    case (lvl)
      1: den = ccir ? 120.0 : 100.0;
      2: den = 250.0;
      3: den = 500.0;
      4: den = 1000.0;
      5: den = 2000.0;
      6: den = 5000.0;
      7: den = 10000.0;
      default: den = 100000.0;
    endcase
    exp_l = $rtoi(rate / den + 0.5);
    if (exp_l < 1) exp_l = 1;
    return (exp_l >= lines) ? 0 : lines - exp_l;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Cycle model
  int m_lvl = 0, m_mode = 3, m_ccir = 0, m_ln = 0, m_sub = 0, m_nm = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lvl = 0; m_mode = 3; m_ccir = 0; m_ln = 0; m_sub = 0;
    end else begin
      m_sub = 0;
      if (field_strobe) begin
        m_nm = 2 * mode_sel_hi + mode_sel_lo;
        if (m_nm == 2) m_lvl = 8 - (4 * spd_pin2 + 2 * spd_pin1 + spd_pin0);
        else if (m_nm < 2) begin
          if (iris_up && !iris_down && m_lvl < 8) m_lvl = m_lvl + 1;
          else if (iris_down && !iris_up && m_lvl > 0) m_lvl = m_lvl - 1;
          if (m_nm == 1 && m_lvl < 1) m_lvl = 1;
        end
        m_mode = m_nm;
        m_ccir = std_ccir;
        m_ln = 0;
      end
      if (line_strobe) begin
        m_sub = (m_mode != 3 && m_ln < ref_limit(m_lvl, m_ccir)) ? 1 : 0;
        if (m_ln < 1023) m_ln = m_ln + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 cycle sub_en", int'(sub_en), m_sub);
      check("R2 cycle speed_idx", int'(speed_idx), m_lvl);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Mid-field switch targets
  int sw_line = -1;
  logic [2:0] sw_pins = 3'b000;
  logic sw_std = 1'b0;

  task automatic run_field(input int nlines, output int cnt);
    cnt = 0;
    for (int l = 0; l < nlines; l++) begin
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        cnt += int'(sub_en);
        if (l == sw_line && c == 0) begin
          {spd_pin2, spd_pin1, spd_pin0} = sw_pins;
          std_ccir = sw_std;
          iris_up = 1'b1;
        end
        line_strobe  = (c == 0);
        field_strobe = (c == 0 && l == 0);
      end
    end
    @(negedge clk);
    cnt += int'(sub_en);
    line_strobe = 1'b0;
    field_strobe = 1'b0;
  endtask

  task automatic set_mode(input logic hi, input logic lo);
    mode_sel_hi = hi;
    mode_sel_lo = lo;
  endtask

  initial begin
    int cnt;
    int exp_lvl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset speed_idx", int'(speed_idx), 0);
    check("R11 reset sub_en", int'(sub_en), 0);

    // Line strobes before any field boundary: no pulses
    cnt = 0;
    for (int l = 0; l < 20; l++) begin
      @(negedge clk); cnt += int'(sub_en); line_strobe = 1'b1;
      @(negedge clk); cnt += int'(sub_en); line_strobe = 1'b0;
      @(negedge clk); cnt += int'(sub_en);
    end
    check("R11 pulses before first field", cnt, 0);

    // Fixed sweep over all codes and both standards, comparator held active
    set_mode(1'b1, 1'b0);
    iris_up = 1'b1;
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 8; v++) begin
        std_ccir = s[0];
        {spd_pin2, spd_pin1, spd_pin0} = v[2:0];
        run_field(s ? 312 : 262, cnt);
        check("R1 R2 fixed speed_idx", int'(speed_idx), 8 - v);
        if (s == 1) check("R4 ccir field count", cnt, ref_limit(8 - v, 1));
        else        check("R3 eia field count", cnt, ref_limit(8 - v, 0));
      end
    end
    iris_up = 1'b0;
    std_ccir = 1'b0;

    // Iris without floor: down to 0 and hold there
    set_mode(1'b0, 1'b0);
    iris_down = 1'b1;
    run_field(262, cnt);
    check("R8 level zero idx", int'(speed_idx), 0);
    check("R8 level zero count", cnt, 0);
    run_field(262, cnt);
    check("R6 bottom saturation", int'(speed_idx), 0);

    // Climb past the top
    iris_down = 1'b0;
    iris_up = 1'b1;
    for (int k = 1; k <= 9; k++) begin
      run_field(262, cnt);
      exp_lvl = (k > 8) ? 8 : k;
      check("R5 iris up step", int'(speed_idx), exp_lvl);
      check("R3 iris count", cnt, ref_limit(exp_lvl, 0));
    end
    check("R6 top saturation", int'(speed_idx), 8);

    // Floored iris: walk down against the floor
    set_mode(1'b0, 1'b1);
    iris_up = 1'b0;
    iris_down = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      run_field(262, cnt);
      exp_lvl = (8 - k < 1) ? 1 : 8 - k;
      check("R7 floored step", int'(speed_idx), exp_lvl);
    end

    // Drop to 0, then enter floored mode with no decision: clamps to 1
    set_mode(1'b0, 1'b0);
    run_field(262, cnt);
    check("R8 back to zero", int'(speed_idx), 0);
    set_mode(1'b0, 1'b1);
    iris_down = 1'b0;
    run_field(262, cnt);
    check("R7 entry clamp", int'(speed_idx), 1);
    check("R7 entry clamp count", cnt, ref_limit(1, 0));

    // Both decisions at once hold
    iris_up = 1'b1;
    iris_down = 1'b1;
    run_field(262, cnt);
    check("R5 both hold", int'(speed_idx), 1);
    iris_up = 1'b0;
    iris_down = 1'b0;

    // Stop
    set_mode(1'b1, 1'b1);
    {spd_pin2, spd_pin1, spd_pin0} = 3'b000;
    run_field(262, cnt);
    check("R9 stop count", cnt, 0);
    check("R9 stop level held", int'(speed_idx), 1);

    // Mid-field change of pins and standard is deferred
    set_mode(1'b1, 1'b0);
    {spd_pin2, spd_pin1, spd_pin0} = 3'b111;
    sw_line = 50;
    sw_pins = 3'b000;
    sw_std = 1'b1;
    run_field(262, cnt);
    sw_line = -1;
    iris_up = 1'b0;
    check("R10 mid-field count", cnt, ref_limit(1, 0));
    check("R10 mid-field idx", int'(speed_idx), 1);
    run_field(312, cnt);
    check("R10 next field takes change", int'(speed_idx), 8);
    check("R4 next field ccir count", cnt, ref_limit(8, 1));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule